// File: doc/BRIEF.md
# Engine inactivity power-down timer

This block decides when a vehicle lamp controller may go to sleep. It keeps an "engine active" state that stays set as long as an inactivity count has not run out. The count advances only on a slow real-time tick. It advances only while all of the following hold:

- the debounced engine input is low;
- the brake state is off;
- the emergency flasher state is off.

Any change event on the engine, brake or emergency inputs reloads the count with the full timeout. The default timeout is sized for roughly five minutes of ticks.

When the count runs out, the block does three things. The active state clears, which raises a power-down request. A one-cycle expiry event is emitted. The count then stops, so it can never wrap around. The surrounding logic uses the request to switch off every lamp and the lamp driver enable. The wake-up path drives the block's reset, and reset restores the full count with the active state set.

The count is split into a low segment and a high segment. The high segment is loaded one above the timeout's upper part, so that it borrows each time the low segment decrements onto zero. The count ends when the high segment itself reaches zero. As a result, a timeout whose low segment is zero takes one extra full low-segment turn.

Top module: `idle_powerdown_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pdn_req` and `exp_evt` are 0, and the count holds its full reload value.
- R2: A high `eng_evt`, `brk_evt` or `emg_evt` on a clock edge reloads the count. After that edge `pdn_req` is 0 and the full number of qualifying ticks is needed again.
- R3: The count advances only on an edge where `rtc_tick` is 1 and `eng_on`, `brk_on` and `emg_on` are all 0. On any other edge the count is unchanged and no expiry can occur.
- R4: The low segment loads with TIMEOUT mod 2^LO_W and the high segment loads with TIMEOUT / 2^LO_W + 1. With a nonzero low-segment value, expiry happens on exactly the TIMEOUT-th qualifying tick after a reload.
- R5: When TIMEOUT mod 2^LO_W is 0, expiry happens on qualifying tick number TIMEOUT + 2^LO_W, because the first borrow needs a full low-segment turn.
- R6: On the edge that takes the final qualifying tick, `pdn_req` goes to 1 and `exp_evt` is 1 for exactly one clock cycle.
- R7: Once expired, the count stops. Further ticks produce no further `exp_evt`, and `pdn_req` stays 1 until an event reloads the count.
- R8: When an event and a qualifying tick arrive on the same edge, the reload wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also driven by wake-up |
| rtc_tick | input | 1 | One-cycle real-time tick |
| eng_on | input | 1 | Debounced engine input level |
| brk_on | input | 1 | Brake light state |
| emg_on | input | 1 | Emergency flasher state |
| eng_evt | input | 1 | Engine input change event |
| brk_evt | input | 1 | Brake state change event |
| emg_evt | input | 1 | Emergency state change event |
| pdn_req | output | 1 | Power-down request (engine-active state inverted) |
| exp_evt | output | 1 | One-cycle expiry event |

## Verification
Both outputs are registered. A tick or event sampled on one rising edge shows its effect on `pdn_req` and `exp_evt` directly after that same edge, with no extra latency. The bench therefore drives inputs on the falling edge and compares both outputs on the following falling edge against a reference count computed from R2 to R8.

Two instances run side by side, one with a nonzero low segment and one with a zero low segment. This exercises the exact expiry tick of R4 and the extra turn of R5. The same-edge case of R8 is placed right before the final tick.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  // Operation applied to the inactivity count on the next edge.
  typedef enum logic [1:0] {
    PDT_HOLD = 2'd0,
    PDT_LOAD = 2'd1,
    PDT_DEC  = 2'd2
  } pdt_op_e;

  // Bundle of the conditions that keep the vehicle "busy".
  typedef struct packed {
    logic eng;
    logic brk;
    logic emg;
  } pdt_busy_t;

endpackage

// File: rtl/pdt_idle_qual.sv
module pdt_idle_qual
  import pdt_pkg::*;
(
  input  logic      rtc_tick,
  input  pdt_busy_t busy,
  input  pdt_busy_t evts,
  input  logic      expired,
  output pdt_op_e   op
);

  logic any_evt;
  logic idle;

  assign any_evt = |evts;
  assign idle    = ~(|busy);

  // Reload has priority over counting; an expired count is frozen.
  always_comb begin
    if (any_evt)
      op = PDT_LOAD;
    else if (rtc_tick && idle && !expired)
      op = PDT_DEC;
    else
      op = PDT_HOLD;
  end

endmodule

// File: rtl/pdt_seg_counter.sv
module pdt_seg_counter
  import pdt_pkg::*;
#(
  parameter int unsigned LO_W    = 8,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned TIMEOUT = 1200
) (
  input  logic    clk,
  input  logic    rst,
  input  pdt_op_e op,
  output logic    last
);

  localparam int unsigned  LO_SPAN = 2 ** LO_W;
  localparam logic [LO_W-1:0] LO_LOAD = LO_W'(TIMEOUT % LO_SPAN);
  // One above the upper part: the borrow is taken when low hits zero.
  localparam logic [HI_W-1:0] HI_LOAD = HI_W'(TIMEOUT / LO_SPAN + 1);
  localparam logic [HI_W-1:0] HI_ONE  = HI_W'(1);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_dec;
  logic [HI_W-1:0] hi_dec;
  logic            lo_borrow;

  assign lo_dec    = lo_q - 1'b1;
  assign hi_dec    = hi_q - 1'b1;
  assign lo_borrow = (lo_dec == '0);
  assign last      = (op == PDT_DEC) && lo_borrow && (hi_q == HI_ONE);

  always_ff @(posedge clk) begin
    if (rst || op == PDT_LOAD) begin
      lo_q <= LO_LOAD;
      hi_q <= HI_LOAD;
    end else if (op == PDT_DEC) begin
      lo_q <= lo_dec;
      if (lo_borrow)
        hi_q <= hi_dec;
    end
  end

endmodule

// File: rtl/pdt_expiry.sv
module pdt_expiry
  import pdt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pdt_op_e op,
  input  logic    last,
  output logic    pdn_req,
  output logic    exp_evt
);

  // pdn_req is the engine-active state held inverted.
  always_ff @(posedge clk) begin
    if (rst) begin
      pdn_req <= 1'b0;
      exp_evt <= 1'b0;
    end else begin
      exp_evt <= last;
      if (op == PDT_LOAD)
        pdn_req <= 1'b0;
      else if (last)
        pdn_req <= 1'b1;
    end
  end

endmodule

// File: rtl/idle_powerdown_timer.sv
module idle_powerdown_timer
  import pdt_pkg::*;
#(
  parameter int unsigned LO_W    = 8,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned TIMEOUT = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic rtc_tick,
  input  logic eng_on,
  input  logic brk_on,
  input  logic emg_on,
  input  logic eng_evt,
  input  logic brk_evt,
  input  logic emg_evt,
  output logic pdn_req,
  output logic exp_evt
);

  pdt_busy_t busy;
  pdt_busy_t evts;
  pdt_op_e   op;
  logic      last;

  assign busy = '{eng: eng_on, brk: brk_on, emg: emg_on};
  assign evts = '{eng: eng_evt, brk: brk_evt, emg: emg_evt};

  pdt_idle_qual qual_i (
    .rtc_tick (rtc_tick),
    .busy     (busy),
    .evts     (evts),
    .expired  (pdn_req),
    .op       (op)
  );

  pdt_seg_counter #(
    .LO_W    (LO_W),
    .HI_W    (HI_W),
    .TIMEOUT (TIMEOUT)
  ) cnt_i (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .last (last)
  );

  pdt_expiry exp_i (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .last    (last),
    .pdn_req (pdn_req),
    .exp_evt (exp_evt)
  );

endmodule

// File: rtl/idle_powerdown_timer_chk.sv
module idle_powerdown_timer_chk (
  input logic clk,
  input logic rst,
  input logic rtc_tick,
  input logic eng_on,
  input logic brk_on,
  input logic emg_on,
  input logic eng_evt,
  input logic brk_evt,
  input logic emg_evt,
  input logic pdn_req,
  input logic exp_evt
);

  logic any_evt;
  logic busy;
  assign any_evt = eng_evt | brk_evt | emg_evt;
  assign busy    = eng_on | brk_on | emg_on | !rtc_tick;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!pdn_req && !exp_evt));

  // R2
  reload_clears_chk: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> (!pdn_req && !exp_evt));

  // R3
  busy_no_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !pdn_req) |=> !pdn_req);

  // R6
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pdn_req) |-> exp_evt);

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    exp_evt |=> !exp_evt);

  // R7
  stay_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pdn_req && !any_evt) |=> (pdn_req && !exp_evt));

endmodule

bind idle_powerdown_timer idle_powerdown_timer_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .rtc_tick (rtc_tick),
  .eng_on   (eng_on),
  .brk_on   (brk_on),
  .emg_on   (emg_on),
  .eng_evt  (eng_evt),
  .brk_evt  (brk_evt),
  .emg_evt  (emg_evt),
  .pdn_req  (pdn_req),
  .exp_evt  (exp_evt)
);

// File: tb/idle_powerdown_timer_tb_top.sv
module idle_powerdown_timer_tb_top;

  localparam int unsigned T_A = 300;  // nonzero low segment (R4)
  localparam int unsigned T_B = 256;  // zero low segment (R5)

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst = 1'b1;
  logic rtc_tick = 1'b0, eng_on = 1'b0, brk_on = 1'b0, emg_on = 1'b0;
  logic eng_evt = 1'b0, brk_evt = 1'b0, emg_evt = 1'b0;
  logic pdn_a, evt_a, pdn_b, evt_b;

  int nvec = 0;
  int nfail = 0;
  int rem_a, rem_b;
  bit mp_a, me_a, mp_b, me_b;

  idle_powerdown_timer #(.TIMEOUT(T_A)) dut_i (
    .clk(clk), .rst(rst), .rtc_tick(rtc_tick), .eng_on(eng_on),
    .brk_on(brk_on), .emg_on(emg_on), .eng_evt(eng_evt),
    .brk_evt(brk_evt), .emg_evt(emg_evt), .pdn_req(pdn_a), .exp_evt(evt_a)
  );

  idle_powerdown_timer #(.TIMEOUT(T_B)) dut_z_i (
    .clk(clk), .rst(rst), .rtc_tick(rtc_tick), .eng_on(eng_on),
    .brk_on(brk_on), .emg_on(emg_on), .eng_evt(eng_evt),
    .brk_evt(brk_evt), .emg_evt(emg_evt), .pdn_req(pdn_b), .exp_evt(evt_b)
  );

  // Qualifying ticks to expiry, from R4 and R5.
  function automatic int eff_ticks(input int unsigned t);
    return (t % 256 == 0) ? int'(t) + 256 : int'(t);
  endfunction

  task automatic chk(input string tag, input logic act, input logic expv);
    nvec++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
    end
  endtask

  task automatic model_step(inout int rem, inout bit mp, output bit me,
                            input int teff, input bit ev, input bit qual);
    me = 1'b0;
    if (ev) begin
      rem = teff;
      mp  = 1'b0;
    end else if (qual && !mp) begin
      rem--;
      if (rem == 0) begin
        mp = 1'b1;
        me = 1'b1;
      end
    end
  endtask

  // Called on a falling edge; applies one cycle and checks after the rise.
  task automatic cyc(input string tag, input bit ee, input bit be, input bit xe,
                     input bit tk, input bit en, input bit bk, input bit em);
    bit ev, qual;
    eng_evt = ee; brk_evt = be; emg_evt = xe;
    rtc_tick = tk; eng_on = en; brk_on = bk; emg_on = em;
    ev   = ee | be | xe;
    qual = tk & !en & !bk & !em;
    model_step(rem_a, mp_a, me_a, eff_ticks(T_A), ev, qual);
    model_step(rem_b, mp_b, me_b, eff_ticks(T_B), ev, qual);
    @(negedge clk);
    chk({tag, " pdn_req A"}, pdn_a, mp_a);
    chk({tag, " exp_evt A"}, evt_a, me_a);
    chk({tag, " pdn_req Z"}, pdn_b, mp_b);
    chk({tag, " exp_evt Z"}, evt_b, me_b);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : stim
    int unused_seed;
    bit ren, rbk, rem_s;
    unused_seed = $urandom(32'h5eed);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset pdn_req A", pdn_a, 1'b0);
    chk("R1 reset exp_evt A", evt_a, 1'b0);
    rst = 1'b0;
    rem_a = eff_ticks(T_A); mp_a = 1'b0;
    rem_b = eff_ticks(T_B); mp_b = 1'b0;

    // R4/R5/R6/R7: uninterrupted idle ticks
    for (int i = 0; i < 520; i++) begin
      cyc("R4/R5/R6/R7 idle", 0, 0, 0, 1, 0, 0, 0);
      if (i == 298) chk("R4 one tick early A", pdn_a, 1'b0);
      if (i == 299) begin
        chk("R4 expiry tick A", pdn_a, 1'b1);
        chk("R6 pulse A", evt_a, 1'b1);
      end
      if (i == 300) chk("R6 pulse ends A", evt_a, 1'b0);
      if (i == 510) chk("R5 one tick early Z", pdn_b, 1'b0);
      if (i == 511) chk("R5 expiry tick Z", pdn_b, 1'b1);
      if (i == 519) chk("R7 held after expiry A", evt_a, 1'b0);
    end

    // R2: events reload and clear the request
    cyc("R2 brake event", 0, 1, 0, 0, 0, 0, 0);
    chk("R2 cleared A", pdn_a, 1'b0);
    chk("R2 cleared Z", pdn_b, 1'b0);
    for (int i = 0; i < 200; i++) cyc("R2 partial", 0, 0, 0, 1, 0, 0, 0);
    cyc("R2 emergency event", 0, 0, 1, 1, 0, 0, 0);
    for (int i = 0; i < 300; i++) cyc("R2 recount", 0, 0, 0, 1, 0, 0, 0);
    chk("R2 full recount A", pdn_a, 1'b1);

    // R3: busy conditions freeze the count
    cyc("R3 engine event", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 600; i++) cyc("R3 engine on", 0, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 600; i++) cyc("R3 brake on", 0, 0, 0, 1, 0, 1, 0);
    for (int i = 0; i < 600; i++) cyc("R3 emergency on", 0, 0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 600; i++) cyc("R3 no tick", 0, 0, 0, 0, 0, 0, 0);
    chk("R3 frozen A", pdn_a, 1'b0);

    // R8: event and tick on the same edge
    cyc("R8 reload", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 299; i++) cyc("R8 approach", 0, 0, 0, 1, 0, 0, 0);
    cyc("R8 event with tick", 1, 0, 0, 1, 0, 0, 0);
    chk("R8 reload wins A", pdn_a, 1'b0);
    for (int i = 0; i < 299; i++) cyc("R8 recount", 0, 0, 0, 1, 0, 0, 0);
    chk("R8 not yet A", pdn_a, 1'b0);
    cyc("R8 final tick", 0, 0, 0, 1, 0, 0, 0);
    chk("R8 expiry A", pdn_a, 1'b1);

    // Random mix
    ren = 1'b0; rbk = 1'b0; rem_s = 1'b0;
    for (int i = 0; i < 60000; i++) begin
      if ($urandom % 700 == 0) ren = !ren;
      if ($urandom % 700 == 0) rbk = !rbk;
      if ($urandom % 700 == 0) rem_s = !rem_s;
      cyc("R2/R3/R4/R6/R7 random",
          ($urandom % 1500 == 0), ($urandom % 1500 == 0), ($urandom % 1500 == 0),
          ($urandom % 2 == 0), ren, rbk, rem_s);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule